// File: doc/BRIEF.md
# Serial Receiver with Framing-Error Lockout

This block receives an asynchronous serial line at 9600 baud with eight data bits, no parity bit and one stop bit. Each good character appears on a byte output together with a one-cycle strobe. The line is oversampled sixteen times per bit. It first passes through a two-stage synchroniser, and a start bit is accepted only if it is still low at its centre.

A guard watches the line health over fixed windows. A window lasts a parameterised number of clock cycles, one second in the default configuration, and windows run back to back from reset. A character whose stop bit is sampled low is a framing error. Such a character is dropped and added to a per-window count. When the count goes past the limit (100 by default), the receive path is switched off for the rest of that window. It is switched back on at the next window boundary. At that moment a one-cycle notice is raised so that neighbouring logic can report the event. Framing errors are still counted while the path is off. The count saturates rather than wrapping and is cleared at every window boundary.

Top module: `uart_lockout_rx`

## Requirements
- R1: A frame of one low start bit, eight data bits sent least significant bit first and a high stop bit is presented on `rx_data`, with `rx_valid` high for exactly one cycle, while the receive path is enabled.
- R2: A frame whose stop bit is sampled low is a framing error. It produces no `rx_valid` strobe and increments `err_cnt`.
- R3: `err_cnt` counts the framing errors of the current window and saturates at 2^CW-1, where CW = clog2(ERR_LIMIT+2). With the default ERR_LIMIT of 100 this is 127.
- R4: A window boundary occurs at every WINDOW_CYCLES-th clock edge after reset release. At a boundary `err_cnt` returns to 0.
- R5: `rx_en` goes low on the cycle after the framing error that raises `err_cnt` to ERR_LIMIT+1. A window with exactly ERR_LIMIT errors leaves `rx_en` high.
- R6: While `rx_en` is low, no `rx_valid` strobe is issued, even for well-formed frames, and framing errors are still counted.
- R7: Once low, `rx_en` stays low until the next window boundary. There it returns high and `reenable_notice` is high for exactly that one cycle. `reenable_notice` never rises at any other time, or at a boundary not preceded by a lockout.
- R8: After reset `rx_en` is 1, `err_cnt` is 0, and `rx_valid` and `reenable_notice` are 0.
- R9: A low pulse on the line shorter than half a bit time is rejected. It produces neither a strobe nor a framing error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last good received character |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_en | output | 1 | Receive path enabled |
| err_cnt | output | CW | Framing errors seen in the current window, saturating |
| reenable_notice | output | 1 | One-cycle pulse when a lockout ends at a window boundary |

## Verification
A sampling phase that is off by even one oversample tick corrupts characters in the full sweep of all byte values. This shows up as a wrong `rx_data` within the same frame. A fault in the error counter or in the lockout comparison moves the edge of `rx_en` away from the 101st error, so it is seen one frame after that error. A saturation fault shows up when the count steps past 127. A fault in the window counter makes `reenable_notice` appear off the expected boundary cycle, or makes `err_cnt` fail to clear there. The exact-limit window shows whether an off-by-one in the lockout test has crept in.

// File: rtl/uart_lockout_pkg.sv
// Shared types for the lockout receiver.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package uart_lockout_pkg;

    // Frame reception phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } rx_phase_t;

endpackage

// File: rtl/rx_line_sync.sv
// Brings the asynchronous serial line into the clock domain.
// Assumes: the line idles high, so the stages reset to 1.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] stage_q;

    // Shift the raw line through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '1;
        else        stage_q <= {stage_q[STAGES-2:0], din};
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rx_frame_core.sv
// Oversampling receiver for frames of one start bit, DATA_BITS data bits
// sent LSB first, no parity and one stop bit. Checks the start bit at its
// centre, samples the data and stop bits at their centres, and raises
// either a gated valid strobe or a framing-error pulse per frame.
// Assumes: line_i is already synchronised; enable_i only gates the strobe.
module rx_frame_core
    import uart_lockout_pkg::*;
#(
    parameter int CLKS_PER_TICK = 814,
    parameter int OSR           = 16,
    parameter int DATA_BITS     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_i,
    input  logic                 enable_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);

    localparam int PW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam int OW = $clog2(OSR);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    logic [PW-1:0]        pre_q;
    logic                 tick;
    rx_phase_t            phase_q;
    logic [OW-1:0]        sub_q;
    logic [IW-1:0]        idx_q;
    logic [DATA_BITS-1:0] shift_q;

    generate
        if (CLKS_PER_TICK > 1) begin : g_prescale
            // Divide the clock down to the oversample tick
            always_ff @(posedge clk) begin
                if (!rst_n)                             pre_q <= '0;
                else if (pre_q == PW'(CLKS_PER_TICK-1)) pre_q <= '0;
                else                                    pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PW'(CLKS_PER_TICK-1));
        end else begin : g_no_prescale
            // Every clock is an oversample tick
            always_ff @(posedge clk) begin
                pre_q <= '0;
            end
            assign tick = 1'b1;
        end
    endgenerate

    // Frame phase sequencer with bit-centre sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            if (tick) begin
                case (phase_q)
                    PH_IDLE: begin
                        sub_q <= '0;
                        if (!line_i) phase_q <= PH_START;
                    end
                    PH_START: begin
                        if (sub_q == OW'(OSR/2-1)) begin
                            sub_q   <= '0;
                            idx_q   <= '0;
                            phase_q <= line_i ? PH_IDLE : PH_DATA;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        if (sub_q == OW'(OSR-1)) begin
                            sub_q   <= '0;
                            shift_q <= {line_i, shift_q[DATA_BITS-1:1]};
                            idx_q   <= idx_q + 1'b1;
                            if (idx_q == IW'(DATA_BITS-1)) phase_q <= PH_STOP;
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                    default: begin
                        if (sub_q == OW'(OSR-1)) begin
                            sub_q   <= '0;
                            phase_q <= PH_IDLE;
                            if (line_i) begin
                                data_o  <= shift_q;
                                valid_o <= enable_i;
                            end else begin
                                ferr_o  <= 1'b1;
                            end
                        end else begin
                            sub_q <= sub_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R2: a frame yields a strobe or an error, never both
    assert_valid_xor_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && ferr_o));

    // R1: a strobe is one cycle wide
    assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

endmodule

// File: rtl/ferr_window_guard.sv
// Counts framing errors over back-to-back windows of WINDOW_CYCLES clocks,
// locks out reception when the count passes ERR_LIMIT, and restores it
// with a one-cycle notice at the next window boundary.
// Assumes: ferr_i is a single-cycle pulse per bad frame.
module ferr_window_guard #(
    parameter int WINDOW_CYCLES = 125_000_000,
    parameter int ERR_LIMIT     = 100,
    parameter int CW            = $clog2(ERR_LIMIT+2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ferr_i,
    output logic          enable_o,
    output logic [CW-1:0] count_o,
    output logic          notice_o
);

    localparam int WW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] LIMIT   = CW'(ERR_LIMIT);

    logic [WW-1:0] win_q;
    logic          wrap;

    assign wrap = (win_q == WW'(WINDOW_CYCLES-1));

    // Window timer, error tally, lockout state and release notice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            count_o  <= '0;
            enable_o <= 1'b1;
            notice_o <= 1'b0;
        end else begin
            notice_o <= 1'b0;
            if (wrap) begin
                win_q   <= '0;
                count_o <= ferr_i ? CW'(1) : '0;
                if (!enable_o) begin
                    enable_o <= 1'b1;
                    notice_o <= 1'b1;
                end
            end else begin
                win_q <= win_q + 1'b1;
                if (ferr_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
                if (ferr_i && count_o >= LIMIT)   enable_o <= 1'b0;
            end
        end
    end

    // R3: within a window the tally never moves backwards (no wrap)
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap) |=> (count_o >= $past(count_o)));

    // R5: being locked out implies the limit was passed
    assert_lock_needs_excess_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_o |-> (count_o > LIMIT));

    // R7: the notice lasts one cycle and marks a rising enable
    assert_notice_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        notice_o |=> !notice_o);
    assert_notice_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        notice_o |-> (enable_o && !$past(enable_o)));

endmodule

// File: rtl/uart_lockout_rx.sv
// Top level: synchroniser, frame receiver and framing-error guard.
// Assumes: rxd idles high; default timing targets 9600 baud at 125 MHz.
module uart_lockout_rx #(
    parameter int CLKS_PER_TICK = 814,
    parameter int OSR           = 16,
    parameter int DATA_BITS     = 8,
    parameter int WINDOW_CYCLES = 125_000_000,
    parameter int ERR_LIMIT     = 100,
    parameter int CW            = $clog2(ERR_LIMIT+2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_en,
    output logic [CW-1:0]        err_cnt,
    output logic                 reenable_notice
);

    logic line_s;
    logic ferr;

    rx_line_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (line_s)
    );

    rx_frame_core #(
        .CLKS_PER_TICK (CLKS_PER_TICK),
        .OSR           (OSR),
        .DATA_BITS     (DATA_BITS)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_s),
        .enable_i (rx_en),
        .data_o   (rx_data),
        .valid_o  (rx_valid),
        .ferr_o   (ferr)
    );

    ferr_window_guard #(
        .WINDOW_CYCLES (WINDOW_CYCLES),
        .ERR_LIMIT     (ERR_LIMIT),
        .CW            (CW)
    ) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .ferr_i   (ferr),
        .enable_o (rx_en),
        .count_o  (err_cnt),
        .notice_o (reenable_notice)
    );

    // R6: no strobe leaves the block while reception is locked out
    assert_no_valid_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_en);

endmodule

// File: tb/sim_uart_lockout_rx.sv
// Bench: one oversample tick per clock (16-clock bits), 40000-cycle windows,
// limit 100. Sweeps all byte values, then drives lockout and exact-limit windows.
module sim_uart_lockout_rx;

    localparam int BITC  = 16;
    localparam int WIN   = 40000;
    localparam int LIM   = 100;
    localparam int CW    = $clog2(LIM+2);
    localparam int SATV  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic [7:0]    rx_data;
    logic          rx_valid;
    logic          rx_en;
    logic [CW-1:0] err_cnt;
    logic          reenable_notice;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int vcount = 0;
    logic [7:0] vlast = 8'h00;
    int ncount = 0;

    always #4 clk = ~clk;

    uart_lockout_rx #(
        .CLKS_PER_TICK (1),
        .OSR           (16),
        .DATA_BITS     (8),
        .WINDOW_CYCLES (WIN),
        .ERR_LIMIT     (LIM),
        .CW            (CW)
    ) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .rxd             (rxd),
        .rx_data         (rx_data),
        .rx_valid        (rx_valid),
        .rx_en           (rx_en),
        .err_cnt         (err_cnt),
        .reenable_notice (reenable_notice)
    );

    // Edge counter matching the window origin at reset release
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Output monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            vcount++;
            vlast = rx_data;
        end
        if (rst_n && reenable_notice) begin
            ncount++;
            check((cyc % WIN) == 0, "R7 notice off boundary", cyc % WIN, 0);
        end
    end

    task automatic send(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        rxd = stop_ok;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic wait_boundary();
        @(negedge clk);
        while ((cyc % WIN) != 0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(rx_en == 1'b1, "R8 rx_en", rx_en, 1);
        check(err_cnt == 0, "R8 err_cnt", err_cnt, 0);
        check(rx_valid == 1'b0, "R8 rx_valid", rx_valid, 0);
        check(reenable_notice == 1'b0, "R8 notice", reenable_notice, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: every byte value, LSB first
        for (int b = 0; b < 256; b++) begin
            v0 = vcount;
            send(8'(b), 1'b1);
            check(vcount == v0 + 1, "R1 strobe count", vcount - v0, 1);
            check(vlast == 8'(b), "R1 data", vlast, b);
        end
        check(err_cnt == 0, "R4 no errors after sweep", err_cnt, 0);
        check(ncount == 0, "R7 no notice without lockout", ncount, 0);

        // R9: short glitch rejected
        v0 = vcount;
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        check(vcount == v0, "R9 glitch strobe", vcount - v0, 0);
        check(err_cnt == 0, "R9 glitch error", err_cnt, 0);

        // Lockout window
        wait_boundary();
        for (int k = 1; k <= LIM; k++) begin
            v0 = vcount;
            send(8'h00, 1'b0);
            if (k == 1) check(vcount == v0, "R2 bad frame discarded", vcount - v0, 0);
            if (k == 1) check(err_cnt == 1, "R2 error counted", err_cnt, 1);
        end
        check(err_cnt == LIM, "R5 count at limit", err_cnt, LIM);
        check(rx_en == 1'b1, "R5 enabled at limit", rx_en, 1);
        send(8'h00, 1'b0);
        check(err_cnt == LIM + 1, "R5 count past limit", err_cnt, LIM + 1);
        check(rx_en == 1'b0, "R5 locked past limit", rx_en, 0);
        v0 = vcount;
        send(8'hA5, 1'b1);
        check(vcount == v0, "R6 no strobe locked", vcount - v0, 0);
        check(err_cnt == LIM + 1, "R6 good frame not counted", err_cnt, LIM + 1);
        send(8'h3C, 1'b0);
        check(err_cnt == LIM + 2, "R6 errors counted locked", err_cnt, LIM + 2);
        for (int k = 0; k < 28; k++) send(8'h00, 1'b0);
        check(err_cnt == SATV, "R3 saturation", err_cnt, SATV);
        check(rx_en == 1'b0, "R7 still locked in window", rx_en, 0);
        check(ncount == 0, "R7 no early notice", ncount, 0);

        // R4 / R7: release at the boundary
        wait_boundary();
        check(reenable_notice == 1'b1, "R7 notice at boundary", reenable_notice, 1);
        check(rx_en == 1'b1, "R7 re-enabled", rx_en, 1);
        check(err_cnt == 0, "R4 cleared at boundary", err_cnt, 0);
        @(negedge clk);
        check(reenable_notice == 1'b0, "R7 notice one cycle", reenable_notice, 0);
        v0 = vcount;
        send(8'h5A, 1'b1);
        check(vcount == v0 + 1 && vlast == 8'h5A, "R1 receive after release", vlast, 8'h5A);

        // R5: exactly the limit within a window
        for (int k = 0; k < LIM; k++) send(8'hFF, 1'b0);
        check(rx_en == 1'b1, "R5 exact limit stays enabled", rx_en, 1);
        check(err_cnt == LIM, "R3 exact count", err_cnt, LIM);
        wait_boundary();
        check(reenable_notice == 1'b0, "R7 no notice without lockout", reenable_notice, 0);
        check(err_cnt == 0, "R4 cleared again", err_cnt, 0);
        check(ncount == 1, "R7 notice total", ncount, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule